// File: doc/BRIEF.md
# Two-master priority bus matrix

This block joins two AHB-Lite style masters, a processor core port and a debug port, to two downstream ports. The first is an external AHB-Lite master port. The second is an internal system-register port that serves the on-chip interrupt controller and debug registers. Each cycle the bus is free, one request is granted. The core always wins, so the debug master only uses cycles the core leaves idle. The granted transfer is steered by address: the fixed window 0xE0000000 to 0xEFFFFFFF goes to the internal port, and every other address goes to the external port.

Only one transfer is in its data phase at a time. The matrix records which master owns that data phase and which port it went to. Read data, response and wait states are returned from that recorded port, and write data is taken from the recorded owner. A master that presents a transfer while it is not granted has its address and control captured. It then sees HREADY low until its captured transfer has been issued and has completed. Inside the internal window, transfers that are not 32-bit words are refused locally with a two-cycle ERROR response.

Top module: `prio_bus_matrix`

## Requirements
- R1: When both masters present a NONSEQ or SEQ transfer (HTRANS[1]=1) in a cycle where the bus is free, the core transfer is the one issued downstream, and the debug transfer waits.
- R2: A granted transfer with an address below 0xE0000000 is issued on the external port as HTRANS=NONSEQ (2'b10), and the internal port stays IDLE.
- R3: A granted transfer with an address at or above 0xF0000000 is issued on the external port, whatever its size.
- R4: A granted transfer with an address from 0xE0000000 to 0xEFFFFFFF is issued on the internal port only. The external port never shows an address inside that window.
- R5: A transfer into the internal window with HSIZE other than 3'b010 (word) is issued to neither port. Its master gets HRESP=1 with HREADY=0 for one cycle, then HRESP=1 with HREADY=1.
- R6: If the external and internal slaves add no wait states, the core's HREADY never goes low because of debug traffic.
- R7: While the data phase in progress is being stalled by its slave (HREADY low), no new transfer is issued on either port, and the owner keeps the grant.
- R8: Read data and response go back to the master from the port chosen in that master's address phase. Write data on both ports comes from the master that owns the data phase.
- R9: A master whose transfer is accepted but not granted sees HREADY=0 until the transfer is issued and completes. The transfer is issued with the address captured when it was accepted, even if the master's address lines change afterwards.
- R10: HTRANS=IDLE (2'b00) from a master is not a request. It reaches no slave, and that master keeps HREADY=1 and HRESP=0.
- R11: A debug transfer held back by core traffic is issued in the first cycle in which the core presents no transfer.
- R12: After reset, both masters see HREADY=1 and HRESP=0, and both downstream ports show HTRANS=IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c_haddr | input | 32 | Core address |
| c_htrans | input | 2 | Core transfer type |
| c_hwrite | input | 1 | Core write flag |
| c_hsize | input | 3 | Core transfer size |
| c_hwdata | input | 32 | Core write data |
| c_hrdata | output | 32 | Read data to core |
| c_hready | output | 1 | Ready to core |
| c_hresp | output | 1 | Response to core (1 = ERROR) |
| d_haddr | input | 32 | Debug address |
| d_htrans | input | 2 | Debug transfer type |
| d_hwrite | input | 1 | Debug write flag |
| d_hsize | input | 3 | Debug transfer size |
| d_hwdata | input | 32 | Debug write data |
| d_hrdata | output | 32 | Read data to debug |
| d_hready | output | 1 | Ready to debug |
| d_hresp | output | 1 | Response to debug (1 = ERROR) |
| x_haddr | output | 32 | External port address |
| x_htrans | output | 2 | External port transfer type |
| x_hwrite | output | 1 | External port write flag |
| x_hsize | output | 3 | External port size |
| x_hwdata | output | 32 | External port write data |
| x_hrdata | input | 32 | External slave read data |
| x_hready | input | 1 | External slave ready |
| x_hresp | input | 1 | External slave response |
| s_haddr | output | 32 | Internal port address |
| s_htrans | output | 2 | Internal port transfer type |
| s_hwrite | output | 1 | Internal port write flag |
| s_hsize | output | 3 | Internal port size |
| s_hwdata | output | 32 | Internal port write data |
| s_hrdata | input | 32 | Internal slave read data |
| s_hready | input | 1 | Internal slave ready |
| s_hresp | input | 1 | Internal slave response |

## Verification
The bench builds the matrix with its default parameters: 32-bit address and data, the internal window at 0xE0000000 to 0xEFFFFFFF, and word size 3'b010. Because the address space is the full 32 bits, the four edge addresses on either side of the window can be driven directly, together with the top of the address space. The external slave model has a wait count the bench can set, so it can produce zero-wait traffic, where the core must never stall, and stalled data phases, where the grant must be held. The two slave models return different address-derived read data, so the bench can tell which port answered.

// File: rtl/bm_pkg.sv
`timescale 1ns/1ps
package bm_pkg;

  // Destination of a granted transfer
  typedef enum logic [1:0] {
    TGT_EXT = 2'd0,
    TGT_INT = 2'd1,
    TGT_ERR = 2'd2
  } tgt_e;

  localparam logic [1:0] HT_IDLE   = 2'b00;
  localparam logic [1:0] HT_NONSEQ = 2'b10;

endpackage

// File: rtl/bm_decode.sv
`timescale 1ns/1ps
module bm_decode
  import bm_pkg::*;
#(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] WIN_LO    = 32'hE000_0000,
  parameter logic [AW-1:0] WIN_HI    = 32'hEFFF_FFFF,
  parameter logic [2:0]    WORD_SIZE = 3'd2
) (
  input  logic [AW-1:0] addr,
  input  logic [2:0]    size,
  output tgt_e          tgt
);

  logic in_win;

  always_comb begin
    in_win = (addr >= WIN_LO) && (addr <= WIN_HI);
    if (!in_win)                 tgt = TGT_EXT;
    else if (size != WORD_SIZE)  tgt = TGT_ERR;
    else                         tgt = TGT_INT;
  end

endmodule

// File: rtl/bm_hold.sv
`timescale 1ns/1ps
// Per-master capture stage: keeps an accepted but ungranted request.
module bm_hold #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         live_v,
  input  logic [W-1:0] live_d,
  input  logic         take,
  output logic         req_v,
  output logic [W-1:0] req_d,
  output logic         pend_q
);

  logic         pend_d;
  logic         cap_en;
  logic [W-1:0] held_q;

  always_comb begin
    pend_d = pend_q;
    if (pend_q) begin
      if (take) pend_d = 1'b0;
    end else if (live_v && !take) begin
      pend_d = 1'b1;
    end
    cap_en = !pend_q && live_v && !take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) held_q <= live_d;
  end

  assign req_v = pend_q | live_v;
  assign req_d = pend_q ? held_q : live_d;

endmodule

// File: rtl/bm_dphase.sv
`timescale 1ns/1ps
// Tracks the single data phase in flight: owner, target, local error.
module bm_dphase
  import bm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic iss_own,
  input  tgt_e iss_tgt,
  input  logic x_rdy,
  input  logic s_rdy,
  output logic bus_rdy,
  output logic dp_v,
  output logic dp_own,
  output tgt_e dp_tgt
);

  logic dp_v_d, dp_own_d, err2_q, err2_d;
  tgt_e dp_tgt_d;

  always_comb begin
    unique case (dp_tgt)
      TGT_EXT: bus_rdy = !dp_v || x_rdy;
      TGT_INT: bus_rdy = !dp_v || s_rdy;
      default: bus_rdy = !dp_v || err2_q;
    endcase
  end

  always_comb begin
    dp_v_d   = dp_v;
    dp_own_d = dp_own;
    dp_tgt_d = dp_tgt;
    err2_d   = err2_q;
    if (bus_rdy) begin
      dp_v_d   = issue;
      dp_own_d = iss_own;
      dp_tgt_d = iss_tgt;
      err2_d   = 1'b0;
    end else if (dp_tgt == TGT_ERR) begin
      err2_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_v   <= 1'b0;
      dp_own <= 1'b0;
      dp_tgt <= TGT_EXT;
      err2_q <= 1'b0;
    end else begin
      dp_v   <= dp_v_d;
      dp_own <= dp_own_d;
      dp_tgt <= dp_tgt_d;
      err2_q <= err2_d;
    end
  end

endmodule

// File: rtl/prio_bus_matrix.sv
`timescale 1ns/1ps
module prio_bus_matrix
  import bm_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            DW        = 32,
  parameter logic [AW-1:0] WIN_LO    = 32'hE000_0000,
  parameter logic [AW-1:0] WIN_HI    = 32'hEFFF_FFFF,
  parameter logic [2:0]    WORD_SIZE = 3'd2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] c_haddr,
  input  logic [1:0]    c_htrans,
  input  logic          c_hwrite,
  input  logic [2:0]    c_hsize,
  input  logic [DW-1:0] c_hwdata,
  output logic [DW-1:0] c_hrdata,
  output logic          c_hready,
  output logic          c_hresp,
  input  logic [AW-1:0] d_haddr,
  input  logic [1:0]    d_htrans,
  input  logic          d_hwrite,
  input  logic [2:0]    d_hsize,
  input  logic [DW-1:0] d_hwdata,
  output logic [DW-1:0] d_hrdata,
  output logic          d_hready,
  output logic          d_hresp,
  output logic [AW-1:0] x_haddr,
  output logic [1:0]    x_htrans,
  output logic          x_hwrite,
  output logic [2:0]    x_hsize,
  output logic [DW-1:0] x_hwdata,
  input  logic [DW-1:0] x_hrdata,
  input  logic          x_hready,
  input  logic          x_hresp,
  output logic [AW-1:0] s_haddr,
  output logic [1:0]    s_htrans,
  output logic          s_hwrite,
  output logic [2:0]    s_hsize,
  output logic [DW-1:0] s_hwdata,
  input  logic [DW-1:0] s_hrdata,
  input  logic          s_hready,
  input  logic          s_hresp
);

  localparam int NM = 2;           // index 0: core, index 1: debug

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          wr;
    logic [2:0]    size;
  } ctl_t;
  localparam int CW = $bits(ctl_t);

  logic [NM-1:0] live_v, hrdy_o, resp_o, req_v, issued, pend;
  logic [1:0]    trans_in [NM];
  logic [CW-1:0] live_d   [NM];
  logic [CW-1:0] req_d    [NM];

  logic bus_rdy, dp_v, dp_own, issue, sel, resp_mux;
  tgt_e dp_tgt, iss_tgt;
  ctl_t win;
  logic [DW-1:0] rdata_mux;

  wire unused_trans_lsb = &{1'b0, c_htrans[0], d_htrans[0]};

  assign trans_in[0] = c_htrans;
  assign trans_in[1] = d_htrans;
  assign live_d[0]   = {c_haddr, c_hwrite, c_hsize};
  assign live_d[1]   = {d_haddr, d_hwrite, d_hsize};

  for (genvar m = 0; m < NM; m++) begin : g_mst
    assign live_v[m] = trans_in[m][1] & hrdy_o[m];
    assign issued[m] = issue && (sel == 1'(m));
    assign hrdy_o[m] = !pend[m] && !(dp_v && dp_own == 1'(m) && !bus_rdy);
    assign resp_o[m] = dp_v && (dp_own == 1'(m)) && resp_mux;

    bm_hold #(.W(CW)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .live_v (live_v[m]),
      .live_d (live_d[m]),
      .take   (issued[m]),
      .req_v  (req_v[m]),
      .req_d  (req_d[m]),
      .pend_q (pend[m])
    );
  end

  // Fixed priority: core first
  always_comb begin
    sel   = req_v[0] ? 1'b0 : 1'b1;
    issue = bus_rdy && (|req_v);
    win   = ctl_t'(req_d[sel]);
  end

  bm_decode #(
    .AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .WORD_SIZE(WORD_SIZE)
  ) u_dec (
    .addr (win.addr),
    .size (win.size),
    .tgt  (iss_tgt)
  );

  bm_dphase u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .iss_own (sel),
    .iss_tgt (iss_tgt),
    .x_rdy   (x_hready),
    .s_rdy   (s_hready),
    .bus_rdy (bus_rdy),
    .dp_v    (dp_v),
    .dp_own  (dp_own),
    .dp_tgt  (dp_tgt)
  );

  always_comb begin
    unique case (dp_tgt)
      TGT_EXT: begin resp_mux = x_hresp; rdata_mux = x_hrdata; end
      TGT_INT: begin resp_mux = s_hresp; rdata_mux = s_hrdata; end
      default: begin resp_mux = 1'b1;    rdata_mux = '0;       end
    endcase
  end

  assign x_htrans = (issue && iss_tgt == TGT_EXT) ? HT_NONSEQ : HT_IDLE;
  assign s_htrans = (issue && iss_tgt == TGT_INT) ? HT_NONSEQ : HT_IDLE;
  assign x_haddr  = win.addr;
  assign x_hwrite = win.wr;
  assign x_hsize  = win.size;
  assign s_haddr  = win.addr;
  assign s_hwrite = win.wr;
  assign s_hsize  = win.size;
  assign x_hwdata = dp_own ? d_hwdata : c_hwdata;
  assign s_hwdata = dp_own ? d_hwdata : c_hwdata;

  assign c_hrdata = rdata_mux;
  assign d_hrdata = rdata_mux;
  assign c_hready = hrdy_o[0];
  assign d_hready = hrdy_o[1];
  assign c_hresp  = resp_o[0];
  assign d_hresp  = resp_o[1];

endmodule

// File: rtl/bm_checker.sv
`timescale 1ns/1ps
module bm_checker #(
  parameter int            AW     = 32,
  parameter logic [AW-1:0] WIN_LO = 32'hE000_0000,
  parameter logic [AW-1:0] WIN_HI = 32'hEFFF_FFFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] c_haddr,
  input logic [1:0]    c_htrans,
  input logic [1:0]    d_htrans,
  input logic          c_hready,
  input logic          c_hresp,
  input logic          d_hready,
  input logic          d_hresp,
  input logic [AW-1:0] x_haddr,
  input logic [1:0]    x_htrans,
  input logic          x_hready,
  input logic [AW-1:0] s_haddr,
  input logic [1:0]    s_htrans,
  input logic          s_hready
);

  logic ext_dp, int_dp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_dp <= 1'b0;
      int_dp <= 1'b0;
    end else begin
      if (x_htrans[1])   ext_dp <= 1'b1;
      else if (x_hready) ext_dp <= 1'b0;
      if (s_htrans[1])   int_dp <= 1'b1;
      else if (s_hready) int_dp <= 1'b0;
    end
  end

  // R4
  win_never_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    x_htrans[1] |-> !((x_haddr >= WIN_LO) && (x_haddr <= WIN_HI)));

  // R4
  single_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(x_htrans[1] && s_htrans[1]));

  // R7
  stall_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_dp && !x_hready) || (int_dp && !s_hready)) |-> (!x_htrans[1] && !s_htrans[1]));

  // R5
  core_err_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_hresp && !c_hready) |=> (c_hresp && c_hready));

  // R5
  dbg_err_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_hresp && !d_hready) |=> (d_hresp && d_hready));

  // R1
  core_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_htrans[1] && c_hready && d_htrans[1] && d_hready &&
     !(ext_dp && !x_hready) && !(int_dp && !s_hready))
    |-> (x_htrans[1] ? (x_haddr == c_haddr) : (s_htrans[1] ? (s_haddr == c_haddr) : 1'b1)));

endmodule

bind prio_bus_matrix bm_checker #(.AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) i_chk (.*);

// File: tb/test_prio_bus_matrix.sv
`timescale 1ns/1ps
module test_prio_bus_matrix;

  localparam logic [31:0] KE = 32'hA5A5_0000;
  localparam logic [31:0] KI = 32'h0000_5A5A;
  localparam logic [31:0] KW = 32'h1234_5678;

  // kind: 0 external, 1 internal, 2 local error
  typedef struct packed {
    logic [31:0] addr;
    logic [2:0]  size;
    logic        wr;
    logic [1:0]  kind;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'hDFFF_FFFC, 3'd2, 1'b0, 2'd0},
    '{32'hE000_0000, 3'd2, 1'b0, 2'd1},
    '{32'hEFFF_FFFC, 3'd2, 1'b0, 2'd1},
    '{32'hF000_0000, 3'd2, 1'b0, 2'd0},
    '{32'h0000_1000, 3'd2, 1'b1, 2'd0},
    '{32'hE000_ED00, 3'd0, 1'b0, 2'd2},
    '{32'hE000_0004, 3'd1, 1'b1, 2'd2},
    '{32'hFFFF_FFF0, 3'd0, 1'b0, 2'd0},
    '{32'hE000_0100, 3'd2, 1'b1, 2'd1}
  };

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic [31:0] c_haddr, d_haddr, c_hwdata, d_hwdata;
  logic [1:0]  c_htrans, d_htrans;
  logic        c_hwrite, d_hwrite;
  logic [2:0]  c_hsize, d_hsize;
  logic [31:0] c_hrdata, d_hrdata;
  logic        c_hready, c_hresp, d_hready, d_hresp;
  logic [31:0] x_haddr, x_hwdata, x_hrdata, s_haddr, s_hwdata, s_hrdata;
  logic [1:0]  x_htrans, s_htrans;
  logic        x_hwrite, s_hwrite, x_hready, s_hready, x_hresp, s_hresp;
  logic [2:0]  x_hsize, s_hsize;

  prio_bus_matrix i_prio_bus_matrix (.*);

  // External slave model with programmable wait states
  int          ext_waits;
  int          ext_cnt, int_cnt, ext_wc;
  logic        ext_busy, ext_wr, int_busy, int_wr;
  logic [31:0] ext_addr, int_addr, ext_wdat, int_wdat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_busy <= 1'b0; ext_wc <= 0; ext_cnt <= 0; ext_addr <= '0; ext_wr <= 1'b0; ext_wdat <= '0;
    end else begin
      if (ext_busy && ext_wc != 0) ext_wc <= ext_wc - 1;
      else if (ext_busy) begin
        ext_busy <= 1'b0;
        if (ext_wr) ext_wdat <= x_hwdata;
      end
      if (x_htrans[1]) begin
        ext_busy <= 1'b1; ext_wc <= ext_waits; ext_addr <= x_haddr;
        ext_wr <= x_hwrite; ext_cnt <= ext_cnt + 1;
      end
    end
  end
  assign x_hready = !(ext_busy && ext_wc != 0);
  assign x_hrdata = ext_addr ^ KE;
  assign x_hresp  = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_busy <= 1'b0; int_cnt <= 0; int_addr <= '0; int_wr <= 1'b0; int_wdat <= '0;
    end else begin
      if (int_busy) begin
        int_busy <= 1'b0;
        if (int_wr) int_wdat <= s_hwdata;
      end
      if (s_htrans[1]) begin
        int_busy <= 1'b1; int_addr <= s_haddr; int_wr <= s_hwrite; int_cnt <= int_cnt + 1;
      end
    end
  end
  assign s_hready = 1'b1;
  assign s_hrdata = int_addr ^ KI;
  assign s_hresp  = 1'b0;

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drv(input bit dbg, input logic [1:0] tr, input logic [31:0] a,
                     input logic [2:0] sz, input bit wr, input logic [31:0] wd);
    if (dbg) begin
      d_htrans = tr; d_haddr = a; d_hsize = sz; d_hwrite = wr; d_hwdata = wd;
    end else begin
      c_htrans = tr; c_haddr = a; c_hsize = sz; c_hwrite = wr; c_hwdata = wd;
    end
  endtask

  function automatic logic rdy(input bit dbg);
    return dbg ? d_hready : c_hready;
  endfunction

  task automatic single(input bit dbg, input vec_t v, output logic [31:0] rd,
                        output logic rsp, output int stall);
    @(negedge clk); drv(dbg, 2'b10, v.addr, v.size, v.wr, '0);
    #5;
    while (!rdy(dbg)) begin @(negedge clk); #5; end
    @(negedge clk); drv(dbg, 2'b00, v.addr, v.size, v.wr, v.addr ^ KW);
    #5;
    stall = 0;
    while (!rdy(dbg)) begin stall++; @(negedge clk); #5; end
    rd  = dbg ? d_hrdata : c_hrdata;
    rsp = dbg ? d_hresp  : c_hresp;
  endtask

  initial begin
    #4_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    ext_waits = 0;
    rst_n = 1'b0;
    drv(1'b0, 2'b00, '0, 3'd2, 1'b0, '0);
    drv(1'b1, 2'b00, '0, 3'd2, 1'b0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R12 reset state
    #5;
    chk("R12 core hready", 32'(c_hready), 1);
    chk("R12 dbg hready",  32'(d_hready), 1);
    chk("R12 resp",        32'({c_hresp, d_hresp}), 0);
    chk("R12 ports idle",  32'({x_htrans, s_htrans}), 0);

    // Vector table: routing, boundaries, size errors (R2 R3 R4 R5 R8)
    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VECS[i];
      automatic bit dbg = (i % 2) == 1;
      automatic int e0 = ext_cnt;
      automatic int i0 = int_cnt;
      logic [31:0] rd; logic rsp; int st;
      single(dbg, v, rd, rsp, st);
      @(posedge clk); #1;
      case (v.kind)
        2'd0: begin
          chk("R2/R3 ext count", 32'(ext_cnt - e0), 1);
          chk("R2/R3 int untouched", 32'(int_cnt - i0), 0);
          chk("R2/R3 ext addr", ext_addr, v.addr);
          if (!v.wr) chk("R8 ext rdata", rd, v.addr ^ KE);
          else       chk("R8 ext wdata", ext_wdat, v.addr ^ KW);
          chk("R8 ext resp", 32'(rsp), 0);
        end
        2'd1: begin
          chk("R4 int count", 32'(int_cnt - i0), 1);
          chk("R4 ext untouched", 32'(ext_cnt - e0), 0);
          if (!v.wr) chk("R8 int rdata", rd, v.addr ^ KI);
          else       chk("R8 int wdata", int_wdat, v.addr ^ KW);
        end
        default: begin
          chk("R5 err resp", 32'(rsp), 1);
          chk("R5 err one wait", 32'(st), 1);
          chk("R5 no access", 32'((ext_cnt - e0) + (int_cnt - i0)), 0);
        end
      endcase
    end

    // Simultaneous requests (R1 R9 R8 R6)
    @(negedge clk);
    drv(1'b0, 2'b10, 32'h0000_0100, 3'd2, 1'b0, '0);
    drv(1'b1, 2'b10, 32'hE000_0008, 3'd2, 1'b0, '0);
    #5;
    chk("R1 core issued ext", 32'({x_htrans, s_htrans}), 32'h8);
    chk("R1 core addr", x_haddr, 32'h0000_0100);
    chk("R9 dbg accepted", 32'(d_hready), 1);
    @(negedge clk);
    drv(1'b0, 2'b00, '0, 3'd2, 1'b0, '0);
    drv(1'b1, 2'b00, 32'h0000_0000, 3'd2, 1'b0, '0);
    #5;
    chk("R6 core no stall", 32'(c_hready), 1);
    chk("R8 core rdata", c_hrdata, 32'h0000_0100 ^ KE);
    chk("R9 dbg waits", 32'(d_hready), 0);
    chk("R9 captured addr issued", s_haddr, 32'hE000_0008);
    chk("R9 int issued", 32'(s_htrans), 32'h2);
    @(negedge clk); #5;
    chk("R8 dbg rdata", d_hrdata, 32'hE000_0008 ^ KI);
    chk("R9 dbg done", 32'(d_hready), 1);

    // Starvation and release (R11 R6)
    @(negedge clk);
    drv(1'b0, 2'b10, 32'h0000_0200, 3'd2, 1'b0, '0);
    drv(1'b1, 2'b10, 32'h0000_9000, 3'd2, 1'b0, '0);
    #5;
    chk("R1 core first", x_haddr, 32'h0000_0200);
    for (int k = 1; k < 5; k++) begin
      @(negedge clk);
      drv(1'b0, 2'b10, 32'h0000_0200 + 32'(4 * k), 3'd2, 1'b0, '0);
      drv(1'b1, 2'b00, 32'h0000_9000, 3'd2, 1'b0, '0);
      #5;
      chk("R6 core never stalls", 32'(c_hready), 1);
      chk("R11 dbg held", 32'(d_hready), 0);
      chk("R1 core back to back", x_haddr, 32'h0000_0200 + 32'(4 * k));
    end
    @(negedge clk);
    drv(1'b0, 2'b00, '0, 3'd2, 1'b0, '0);
    #5;
    chk("R11 dbg issued when core idle", x_haddr, 32'h0000_9000);
    chk("R11 ext nonseq", 32'(x_htrans), 32'h2);
    chk("R8 last core rdata", c_hrdata, 32'h0000_0210 ^ KE);
    @(negedge clk); #5;
    chk("R11 dbg complete", d_hrdata, 32'h0000_9000 ^ KE);

    // Wait states hold grant (R7)
    ext_waits = 2;
    @(negedge clk);
    drv(1'b0, 2'b10, 32'h0000_0300, 3'd2, 1'b0, '0);
    #5;
    chk("R7 core issued", x_haddr, 32'h0000_0300);
    @(negedge clk);
    drv(1'b0, 2'b00, '0, 3'd2, 1'b0, '0);
    drv(1'b1, 2'b10, 32'hE000_0010, 3'd2, 1'b0, '0);
    #5;
    chk("R7 core wait 1", 32'(c_hready), 0);
    chk("R7 no issue in wait 1", 32'({x_htrans, s_htrans}), 0);
    @(negedge clk);
    drv(1'b1, 2'b00, '0, 3'd2, 1'b0, '0);
    #5;
    chk("R7 core wait 2", 32'(c_hready), 0);
    chk("R7 no issue in wait 2", 32'({x_htrans, s_htrans}), 0);
    chk("R9 dbg held in wait", 32'(d_hready), 0);
    @(negedge clk); #5;
    chk("R7 core done", c_hrdata, 32'h0000_0300 ^ KE);
    chk("R7 dbg now issued", s_haddr, 32'hE000_0010);
    @(negedge clk); #5;
    chk("R8 dbg after wait", d_hrdata, 32'hE000_0010 ^ KI);
    ext_waits = 0;

    // IDLE is no request (R10)
    begin
      automatic int e0 = ext_cnt;
      automatic int i0 = int_cnt;
      @(negedge clk);
      drv(1'b1, 2'b00, 32'hE000_0000, 3'd2, 1'b1, '0);
      drv(1'b0, 2'b00, 32'h0000_0040, 3'd2, 1'b1, '0);
      #5;
      chk("R10 ports idle", 32'({x_htrans, s_htrans}), 0);
      @(negedge clk); #5;
      chk("R10 hready", 32'({c_hready, d_hready}), 32'h3);
      chk("R10 okay", 32'({c_hresp, d_hresp}), 0);
      @(posedge clk); #1;
      chk("R10 no access", 32'((ext_cnt - e0) + (int_cnt - i0)), 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule